// File: doc/BRIEF.md
# Frame-Synchronous Scrambler / Descrambler

This block applies an additive, frame-synchronous pseudo-random sequence to a byte stream at the 155 Mbit/s line rate in byte-parallel form. It sits after the frame generator on the transmit side, or after the framer on the receive side. Scrambling and descrambling are the same XOR operation, so one design serves both directions. The same block can also be placed once per low-rate tributary, each copy with its own enable.

A seven-stage generator with polynomial 1 + x^6 + x^7 yields eight sequence bits per valid byte. The bit that comes first in time goes to the byte MSB. The upstream framer marks the frame-start byte and every byte of the first section-overhead row. Those row-one bytes pass through untouched and hold the generator at its all-ones seed, so the first byte after them is combined with the start of the sequence. A software enable forces plain pass-through, while the generator keeps its position in the frame.

There is one register stage. The valid and frame-start markers come out aligned with the processed byte.

Top module: `fs_scrambler`

## Requirements
- R1: While reset is asserted and in the first sample after it, `dout`, `dout_valid` and `dout_sof` are all zero.
- R2: `dout_valid` follows `din_valid` one clock later. `dout_sof` is high one clock after a valid byte that has `din_sof` set, and is never high without `dout_valid`.
- R3: A valid byte with `din_oh_row1` high appears unchanged on `dout` one clock later, and it leaves the generator at the all-ones seed.
- R4: The first valid byte after row-one overhead is XORed with 0xFE and the second with 0x04. These values come from the seed 1111111, polynomial 1 + x^6 + x^7, and byte bit 7 being the earliest sequence bit.
- R5: Each further valid payload byte k (k = 0 for the first byte after the seed) is XORed with sequence bits 8k to 8k+7, taken modulo the 127-bit period. The generator therefore advances exactly eight steps per valid payload byte and wraps without loss.
- R6: A cycle with `din_valid` low does not advance the sequence and leaves `dout` at its previous value.
- R7: With `scr_enable` low, valid bytes pass unchanged but still advance the generator. Re-enabling mid-frame resumes at the sequence position of the byte count.
- R8: A valid byte with `din_sof` high and `din_oh_row1` low starts the sequence at the seed, so that byte is XORed with 0xFE.
- R9: Passing the scrambled output of a frame through the block again, with the same markers, restores the original bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Input byte |
| din_valid | input | 1 | Input byte qualifier |
| din_sof | input | 1 | Marks the first byte of a frame |
| din_oh_row1 | input | 1 | Marks bytes of the first section-overhead row |
| scr_enable | input | 1 | 1 = apply sequence, 0 = pass through |
| dout | output | 8 | Processed byte, one clock after input |
| dout_valid | output | 1 | Delayed qualifier |
| dout_sof | output | 1 | Delayed frame-start marker |

## Verification
The assertions take for granted that the frame-position markers are meaningful only when `din_valid` is high. They also assume that `din_sof` and `din_oh_row1` come from a framer and do not toggle on idle cycles in a way that matters. In the stimulus, markers are driven only together with a valid byte and are cleared on idle cycles. The stimulus also keeps `scr_enable` steady within each byte. Expected bytes come from a bit-serial model of the recurrence built in the bench, not from the byte-parallel generator.

// File: rtl/fs_scr_pkg.sv
`timescale 1ns/1ps
package fs_scr_pkg;
    // Generator length and byte width for the 1 + x^6 + x^7 sequence.
    localparam int unsigned GEN_LEN   = 7;
    localparam int unsigned BYTE_BITS = 8;
    // Stage feeding back together with the last stage (x^6 term).
    localparam int unsigned GEN_TAP   = 5;

    typedef enum logic [1:0] {
        BYTE_IDLE     = 2'd0,
        BYTE_OVERHEAD = 2'd1,
        BYTE_PAYLOAD  = 2'd2
    } byte_kind_e;
endpackage

// File: rtl/fs_keystream.sv
`timescale 1ns/1ps
module fs_keystream #(
    parameter int unsigned LEN   = 7,
    parameter int unsigned WIDTH = 8,
    parameter int unsigned TAP   = 5
) (
    input  logic [LEN-1:0]   state_cur,
    output logic [WIDTH-1:0] key,
    output logic [LEN-1:0]   state_nxt
);
    localparam int unsigned TOP = LEN - 1;

    logic [LEN-1:0] chain [WIDTH+1];

    assign chain[0] = state_cur;

    // Unroll WIDTH shift steps; earliest bit lands on the MSB of key.
    for (genvar i = 0; i < WIDTH; i++) begin : g_step
        assign key[WIDTH-1-i] = chain[i][TOP];
        assign chain[i+1]     = {chain[i][TOP-1:0], chain[i][TOP] ^ chain[i][TAP]};
    end

    assign state_nxt = chain[WIDTH];
endmodule

// File: rtl/fs_seq_ctrl.sv
`timescale 1ns/1ps
module fs_seq_ctrl
    import fs_scr_pkg::*;
#(
    parameter int unsigned LEN = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  byte_kind_e     kind,
    input  logic           sof,
    input  logic [LEN-1:0] adv_state,
    output logic [LEN-1:0] use_state
);
    localparam logic [LEN-1:0] SEED = {LEN{1'b1}};

    typedef struct packed {
        logic [LEN-1:0] gen;
    } ctrl_t;

    ctrl_t st_d, st_q;

    // The frame-start byte always draws from the seed.
    assign use_state = sof ? SEED : st_q.gen;

    always_comb begin
        st_d = st_q;
        unique case (kind)
            BYTE_OVERHEAD: st_d.gen = SEED;
            BYTE_PAYLOAD:  st_d.gen = adv_state;
            default:       st_d.gen = st_q.gen;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gen <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    AST_SEED_AFTER_OH: assert property (@(posedge clk) disable iff (!rst_n)
        kind == BYTE_OVERHEAD |=> st_q.gen == SEED); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        kind == BYTE_IDLE |=> $stable(st_q.gen)); // R6
    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        kind == BYTE_PAYLOAD |=> st_q.gen != '0); // R5
endmodule

// File: rtl/fs_mix.sv
`timescale 1ns/1ps
module fs_mix #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic             valid_in,
    input  logic             sof_in,
    input  logic             bypass,
    input  logic [WIDTH-1:0] key,
    output logic [WIDTH-1:0] data_out,
    output logic             valid_out,
    output logic             sof_out
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             valid;
        logic             sof;
    } mix_t;

    mix_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = valid_in;
        r_d.sof   = valid_in & sof_in;
        if (valid_in) begin
            r_d.data = bypass ? data_in : (data_in ^ key);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_out  = r_q.data;
    assign valid_out = r_q.valid;
    assign sof_out   = r_q.sof;

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out); // R2
    AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out && $stable(data_out)); // R6
    AST_BYPASS_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && bypass |=> data_out == $past(data_in)); // R3
endmodule

// File: rtl/fs_scrambler.sv
`timescale 1ns/1ps
module fs_scrambler
    import fs_scr_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_BITS,
    parameter int unsigned GEN_W  = GEN_LEN,
    parameter int unsigned FB_TAP = GEN_TAP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              din_valid,
    input  logic              din_sof,
    input  logic              din_oh_row1,
    input  logic              scr_enable,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              dout_sof
);
    byte_kind_e        kind;
    logic [GEN_W-1:0]  cur_state;
    logic [GEN_W-1:0]  nxt_state;
    logic [DATA_W-1:0] key;
    logic              pass_thru;

    always_comb begin
        if (!din_valid) begin
            kind = BYTE_IDLE;
        end else if (din_oh_row1) begin
            kind = BYTE_OVERHEAD;
        end else begin
            kind = BYTE_PAYLOAD;
        end
    end

    assign pass_thru = din_oh_row1 | ~scr_enable;

    fs_seq_ctrl #(.LEN(GEN_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .sof       (din_sof),
        .adv_state (nxt_state),
        .use_state (cur_state)
    );

    fs_keystream #(.LEN(GEN_W), .WIDTH(DATA_W), .TAP(FB_TAP)) i_key (
        .state_cur (cur_state),
        .key       (key),
        .state_nxt (nxt_state)
    );

    fs_mix #(.WIDTH(DATA_W)) i_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (din),
        .valid_in  (din_valid),
        .sof_in    (din_sof),
        .bypass    (pass_thru),
        .key       (key),
        .data_out  (dout),
        .valid_out (dout_valid),
        .sof_out   (dout_sof)
    );

    AST_SOF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        dout_sof |-> dout_valid); // R2
    AST_SOF_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        din_valid && din_sof |=> dout_sof); // R2
    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        din_valid && !scr_enable |=> dout == $past(din)); // R7
endmodule

// File: tb/test_fs_scrambler.sv
`timescale 1ns/1ps
module test_fs_scrambler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic       din_valid = 1'b0;
    logic       din_sof = 1'b0;
    logic       din_oh_row1 = 1'b0;
    logic       scr_enable = 1'b1;
    logic [7:0] dout;
    logic       dout_valid;
    logic       dout_sof;

    int total = 0;
    int bad = 0;
    bit seqb [127];
    logic [7:0] saved_in [16];
    logic [7:0] saved_out [16];

    always #2.5 clk = ~clk;

    fs_scrambler i_fs_scrambler (
        .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
        .din_sof(din_sof), .din_oh_row1(din_oh_row1), .scr_enable(scr_enable),
        .dout(dout), .dout_valid(dout_valid), .dout_sof(dout_sof)
    );

    // Bit-serial model: a[n] = a[n-7] ^ a[n-6], seed of seven ones.
    initial begin
        for (int n = 0; n < 7; n++) seqb[n] = 1'b1;
        for (int n = 7; n < 127; n++) seqb[n] = seqb[n-7] ^ seqb[n-6];
    end

    function automatic logic [7:0] key_at(input int k);
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[7-j] = seqb[(8*k + j) % 127];
        return b;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic s, input logic oh, input logic en);
        @(negedge clk);
        din = d; din_valid = 1'b1; din_sof = s; din_oh_row1 = oh; scr_enable = en;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        din_valid = 1'b0; din_sof = 1'b0; din_oh_row1 = 1'b0; din = 8'hA5;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 data", dout, 8'h00);
        chk("R1 valid", {7'd0, dout_valid}, 8'h01 & 8'h00);
        chk("R1 sof", {7'd0, dout_sof}, 8'h00);
    endtask

    task automatic send_oh(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'(8'h30 + i);
            send(d, i == 0, 1'b1, 1'b1);
            chk("R3 overhead pass", dout, d);
            chk("R2 valid", {7'd0, dout_valid}, 8'h01);
            chk("R2 sof", {7'd0, dout_sof}, (i == 0) ? 8'h01 : 8'h00);
        end
    endtask

    task automatic t_basic_frame();
        send_oh(9);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        chk("R4 first key", dout, 8'hFE);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        chk("R4 second key", dout, 8'h04);
        for (int k = 2; k < 40; k++) begin
            logic [7:0] d;
            d = 8'(k * 37);
            send(d, 1'b0, 1'b0, 1'b1);
            chk("R5 sequence", dout, d ^ key_at(k));
        end
    endtask

    task automatic t_idle();
        logic [7:0] last;
        send_oh(3);
        send(8'h11, 1'b0, 1'b0, 1'b1);
        chk("R5 after reseed", dout, 8'h11 ^ key_at(0));
        last = dout;
        idle();
        chk("R2 idle valid", {7'd0, dout_valid}, 8'h00);
        chk("R6 data held", dout, last);
        idle();
        chk("R6 data held 2", dout, last);
        send(8'h22, 1'b0, 1'b0, 1'b1);
        chk("R6 no advance", dout, 8'h22 ^ key_at(1));
    endtask

    task automatic t_disable();
        send_oh(3);
        send(8'h5A, 1'b0, 1'b0, 1'b1);
        chk("R5 k0", dout, 8'h5A ^ key_at(0));
        for (int k = 1; k < 4; k++) begin
            send(8'(8'hC0 + k), 1'b0, 1'b0, 1'b0);
            chk("R7 pass", dout, 8'(8'hC0 + k));
        end
        send(8'h77, 1'b0, 1'b0, 1'b1);
        chk("R7 resume", dout, 8'h77 ^ key_at(4));
    endtask

    task automatic t_sof_payload();
        send(8'h00, 1'b1, 1'b0, 1'b1);
        chk("R8 sof seed", dout, 8'hFE);
        chk("R8 sof marker", {7'd0, dout_sof}, 8'h01);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        chk("R8 next", dout, 8'h04);
    endtask

    task automatic t_roundtrip();
        send_oh(3);
        for (int k = 0; k < 16; k++) begin
            saved_in[k] = 8'(k * 91 + 3);
            send(saved_in[k], 1'b0, 1'b0, 1'b1);
            saved_out[k] = dout;
        end
        send_oh(3);
        for (int k = 0; k < 16; k++) begin
            send(saved_out[k], 1'b0, 1'b0, 1'b1);
            chk("R9 restore", dout, saved_in[k]);
        end
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_basic_frame();
        t_idle();
        t_disable();
        t_sof_payload();
        t_basic_frame();
        t_roundtrip();
        idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule